// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single PWM timer channel. It counts down a 16-bit working counter on ticks derived from the system clock. An 8-bit prescaler divides the clock by its value plus one. A divider stage then divides by 2, 4, 8 or 16. The channel drives a PWM output level. It raises a one-cycle interrupt pulse when the count reaches zero, and it exposes the live count for reading.

Software never writes the working counter or the working compare register directly. It writes a count buffer and a compare buffer. The working registers take these values in two cases: at once, on a manual-update command, or when a period finishes at zero with auto-reload set. With auto-reload clear, the channel stops at zero and stays there. The buffers can therefore be rewritten during a period, and the new values take effect only on the next period.

The register interface is a plain write-strobe / read-strobe bus with combinational read data.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset, every readable location returns 0, `pwm_out` is 0 and `irq` is 0.
- R2: While running, the working counter steps once every (P+1)×D system clock cycles. P is the prescaler field and D = 2 << S, where S is the 2-bit divider select. The first step comes (P+1)×D cycles after the write that sets the run bit.
- R3: A write to the control word (address 1) with bit 1 set copies both buffers into the working registers on that clock edge and forces `pwm_out` low. Bit 1 always reads back as 0.
- R4: On each step the working counter decrements by one while it is non-zero. When a step finds it at zero and auto-reload (control bit 2) is set, both working registers are loaded from the buffers.
- R5: With auto-reload clear, a counter at zero holds at zero and raises no further interrupt.
- R6: `pwm_out` goes high on the step where the decremented count equals the working compare value. It returns low at every reload.
- R7: `irq` is a one-cycle pulse on the edge where a step brings the count from 1 to 0, but only when the interrupt enable (control bit 3) is set.
- R8: While the run bit (control bit 0) is clear, the counter and `pwm_out` are frozen, except for a manual update.
- R9: The register map is as follows. Address 0 holds the prescaler in bits 7:0 and the divider select in bits 9:8. Address 1 is the control word, with bit 0 run, bit 1 update (command), bit 2 auto-reload and bit 3 interrupt enable. Address 2 is the count buffer and address 3 is the compare buffer. Address 4 returns the live count and ignores writes.
- R10: Buffer writes during a period do not change the current period. The next reload uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| addr | input | 3 | Register address |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Combinational read data |
| pwm_out | output | 1 | PWM output level |
| irq | output | 1 | One-cycle zero-reached interrupt pulse |

## Verification
The assertions assume that the tick period is at least two clock cycles, which the divider's minimum of 2 guarantees. They also assume that a manual update and a tick may coincide, with the update taking priority. A count buffer of 1 therefore still leaves a gap between interrupt pulses. The stimulus issues at most one register write per cycle. It places buffer rewrites between steps, so that the model's ordering within each cycle (step using the old buffers, then the write) matches the bus timing. Before every trace it stops the channel and issues a manual update, so each run starts from a known counter and output state.

// File: rtl/pwm_chan_pkg.sv
// Shared constants for the PWM channel: the fixed register address map and
// the bit positions of the control word. Assumes a 3-bit register address.
package pwm_chan_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTB = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
    localparam logic [ADDR_W-1:0] A_OBS  = 3'd4;

    localparam int CTL_RUN = 0;
    localparam int CTL_UPD = 1;
    localparam int CTL_ARL = 2;
    localparam int CTL_IEN = 3;

    typedef struct packed {
        logic ien;
        logic arl;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwm_chan_regs.sv
// Register file of the channel. It holds the clock configuration, the
// control bits and the two buffers, issues the one-cycle manual-update
// strobe and multiplexes the read data. Assumes that DATA_W covers
// both the counter width and the prescaler plus select fields.
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [PRE_W-1:0]  pre_val,
    output logic [SEL_W-1:0]  div_sel,
    output ctrl_t             ctrl,
    output logic              upd,
    output logic [CNT_W-1:0]  cnt_buf,
    output logic [CNT_W-1:0]  cmp_buf
);
    localparam int CFG_W = PRE_W + SEL_W;

    // Manual update: a command bit of a control write, never stored
    assign upd = wr_en && (addr == A_CTRL) && wdata[CTL_UPD];

    // Register writes, one location per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val <= '0;
            div_sel <= '0;
            ctrl    <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG: begin
                    pre_val <= wdata[PRE_W-1:0];
                    div_sel <= wdata[PRE_W +: SEL_W];
                end
                A_CTRL: begin
                    ctrl.run <= wdata[CTL_RUN];
                    ctrl.arl <= wdata[CTL_ARL];
                    ctrl.ien <= wdata[CTL_IEN];
                end
                A_CNTB:  cnt_buf <= wdata[CNT_W-1:0];
                A_CMPB:  cmp_buf <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero when no read is strobed
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CFG:   rdata = DATA_W'({div_sel, pre_val});
                A_CTRL:  rdata = DATA_W'({ctrl.ien, ctrl.arl, 1'b0, ctrl.run});
                A_CNTB:  rdata = DATA_W'(cnt_buf);
                A_CMPB:  rdata = DATA_W'(cmp_buf);
                A_OBS:   rdata = DATA_W'(live_cnt);
                default: rdata = '0;
            endcase
        end
    end

    // Elaboration check of the width assumptions
    if (DATA_W < CNT_W || DATA_W < CFG_W) begin : g_width_bad
        initial $error("pwm_chan_regs: DATA_W too narrow");
    end
endmodule

// File: rtl/pwm_chan_tickgen.sv
// Tick generator: an (P+1) prescaler followed by a divide-by-(2<<S) stage.
// Emits a one-cycle tick every (P+1)*(2<<S) cycles while run is high.
// Both counters clear while stopped, so the first tick after a start
// arrives one full period later. Assumes SEL_W selects at most 2**SEL_W.
module pwm_chan_tickgen #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_val,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int DIV_W = 1 << SEL_W;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   div_span;
    logic [DIV_W-1:0] div_last;
    logic             pre_hit;
    logic             div_hit;

    // Divider length 2<<S, and its terminal count
    assign div_span = (DIV_W+1)'(2) << div_sel;
    assign div_last = div_span[DIV_W-1:0] - DIV_W'(1);

    // Terminal detection; >= recovers from a configuration shrink mid-run
    assign pre_hit = (pre_cnt >= pre_val);
    assign div_hit = (div_cnt >= div_last);
    assign tick    = run && pre_hit && div_hit;

    // Prescaler and divider counters, held clear while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_hit ? '0 : div_cnt + DIV_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pwm_chan_core.sv
// Working counter, working compare register, PWM level and interrupt pulse.
// A manual update loads both buffers and takes priority over a tick.
// On a tick the counter decrements; at zero it reloads when auto-reload
// is set and otherwise holds. Assumes ticks are at least two cycles apart.
module pwm_chan_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             upd,
    input  logic             arl,
    input  logic             ien,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             pwm_out,
    output logic             irq
);
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt_dec;
    logic             at_zero;
    logic             last_step;

    assign cnt_dec   = cnt - CNT_W'(1);
    assign at_zero   = (cnt == '0);
    assign last_step = (cnt == CNT_W'(1));

    // Counter, compare and output level sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmp     <= '0;
            pwm_out <= 1'b0;
        end else if (upd) begin
            cnt     <= cnt_buf;
            cmp     <= cmp_buf;
            pwm_out <= 1'b0;
        end else if (tick) begin
            if (at_zero) begin
                if (arl) begin
                    cnt     <= cnt_buf;
                    cmp     <= cmp_buf;
                    pwm_out <= 1'b0;
                end
            end else begin
                cnt <= cnt_dec;
                if (cnt_dec == cmp) begin
                    pwm_out <= 1'b1;
                end
            end
        end
    end

    // One-cycle interrupt on the 1 -> 0 step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= !upd && tick && last_step && ien;
        end
    end
endmodule

// File: rtl/pwm_chan_top.sv
// Top of the PWM channel: register file, tick generator and counting core.
// Assumes a single writer issuing at most one register access per cycle.
module pwm_chan_top
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out,
    output logic              irq
);
    logic [PRE_W-1:0] pre_val;
    logic [SEL_W-1:0] div_sel;
    ctrl_t            ctrl;
    logic             upd;
    logic [CNT_W-1:0] cnt_buf;
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] live_cnt;
    logic             tick;
    logic             run_q;
    logic             arl_q;

    assign run_q = ctrl.run;
    assign arl_q = ctrl.arl;

    pwm_chan_regs #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .live_cnt(live_cnt), .rdata(rdata),
        .pre_val(pre_val), .div_sel(div_sel), .ctrl(ctrl), .upd(upd),
        .cnt_buf(cnt_buf), .cmp_buf(cmp_buf)
    );

    pwm_chan_tickgen #(
        .PRE_W(PRE_W), .SEL_W(SEL_W)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .pre_val(pre_val), .div_sel(div_sel), .tick(tick)
    );

    pwm_chan_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .upd(upd),
        .arl(arl_q), .ien(ctrl.ien), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
        .cnt(live_cnt), .pwm_out(pwm_out), .irq(irq)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
// Property checker for the PWM channel, bound into every pwm_chan_top.
// Assumes it sees the internal tick, update strobe and control bits.
module pwm_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             pwm_out,
    input logic [CNT_W-1:0] live_cnt,
    input logic             tick,
    input logic             run,
    input logic             upd,
    input logic             arl
);
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (live_cnt == '0));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !tick) |=> $stable(live_cnt));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !upd) |=> ($stable(live_cnt) && $stable(pwm_out)));

    // R5
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == '0 && !arl && !upd) |=> (live_cnt == '0));

    // R3
    upd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !pwm_out);
endmodule

bind pwm_chan_top pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .pwm_out(pwm_out),
    .live_cnt(live_cnt), .tick(tick), .run(run_q), .upd(upd), .arl(arl_q)
);

// File: tb/sim_pwm_chan_top.sv
`timescale 1ns/1ps
module sim_pwm_chan_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pwm_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_chan_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one register; returns just after the capturing edge
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = 3'(a); wdata = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Combinational read at a negedge
    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'(a);
        #1 v = int'(rdata);
        rd_en = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        int v;
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk(v == 0, "R1 reset read", v, 0);
        end
        chk(pwm_out == 1'b0, "R1 reset pwm", int'(pwm_out), 0);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
    endtask

    // R9 map, R3 manual update, R8 freeze while stopped
    task automatic t_regs();
        int v;
        wr(0, 'h2A5);
        rd(0, v); chk(v == 'h2A5, "R9 cfg readback", v, 'h2A5);
        wr(2, 'h1234);
        wr(3, 'h0F0F);
        rd(2, v); chk(v == 'h1234, "R9 count buffer", v, 'h1234);
        rd(3, v); chk(v == 'h0F0F, "R9 compare buffer", v, 'h0F0F);
        rd(4, v); chk(v == 0, "R10 buffers not live before update", v, 0);
        wr(1, 'b1110);
        rd(1, v); chk(v == 'b1100, "R9 ctrl readback, R3 update reads 0", v, 'b1100);
        rd(4, v); chk(v == 'h1234, "R3 manual update loads count", v, 'h1234);
        wr(4, 'hBEEF);
        rd(4, v); chk(v == 'h1234, "R9 observe write ignored", v, 'h1234);
        repeat (12) @(negedge clk);
        rd(4, v); chk(v == 'h1234, "R8 frozen while stopped", v, 'h1234);
        chk(pwm_out == 1'b0, "R3 pwm low after update", int'(pwm_out), 0);
    endtask

    // Cycle-accurate trace against a model of R2/R4/R5/R6/R7/R10
    task automatic t_trace(input int pre, input int sel, input int cb, input int mb,
                           input bit ar, input bit ie, input int n,
                           input int rew_at, input int ncb, input int nmb,
                           input string tag);
        int per, mc, mm, bcb, bmb, pend_a, pend_d, v;
        bit mo, mi;
        per = (pre + 1) * (2 << sel);
        wr(1, 0);
        wr(0, (sel << 8) | pre);
        wr(2, cb);
        wr(3, mb);
        wr(1, (int'(ie) << 3) | (int'(ar) << 2) | 2);
        mc = cb; mm = mb; mo = 1'b0; bcb = cb; bmb = mb; pend_a = -1; pend_d = 0;
        wr(1, (int'(ie) << 3) | (int'(ar) << 2) | 1);
        for (int m = 0; m < n; m++) begin
            @(negedge clk);
            wr_en = 1'b0;
            mi = 1'b0;
            if (m > 0 && (m % per) == 0) begin
                if (mc == 0) begin
                    if (ar) begin mc = bcb; mm = bmb; mo = 1'b0; end
                end else begin
                    mc = mc - 1;
                    if (mc == mm) mo = 1'b1;
                    if (mc == 0 && ie) mi = 1'b1;
                end
            end
            if (pend_a == 2) bcb = pend_d;
            if (pend_a == 3) bmb = pend_d;
            pend_a = -1;
            rd_en = 1'b1; addr = 3'd4;
            #1 v = int'(rdata);
            rd_en = 1'b0;
            chk(v == mc, {tag, " R4 live count"}, v, mc);
            chk(pwm_out == mo, {tag, " R6 pwm level"}, int'(pwm_out), int'(mo));
            chk(irq == mi, {tag, " R7 irq pulse"}, int'(irq), int'(mi));
            if (m == rew_at || m == rew_at + 1) begin
                pend_a = (m == rew_at) ? 2 : 3;
                pend_d = (m == rew_at) ? ncb : nmb;
                wr_en = 1'b1; addr = 3'(pend_a); wdata = 16'(pend_d);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R8: clearing run freezes count and output mid-period
    task automatic t_freeze();
        int v0, v1;
        bit p0;
        wr(1, 0);
        wr(0, 0);
        wr(2, 9);
        wr(3, 6);
        wr(1, 'b0110);
        wr(1, 'b0101);
        repeat (8) @(negedge clk);
        wr(1, 'b0100);
        rd(4, v0);
        p0 = pwm_out;
        chk(v0 == 5, "R8 count at stop", v0, 5);
        chk(p0 == 1'b1, "R8 pwm at stop", int'(p0), 1);
        repeat (20) @(negedge clk);
        rd(4, v1);
        chk(v1 == v0, "R8 count frozen", v1, v0);
        chk(pwm_out == p0, "R8 pwm frozen", int'(pwm_out), int'(p0));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        // R2 fastest rate, R10 rewrite 3/1 -> 2/0 mid-period
        t_trace(0, 0, 3, 1, 1'b1, 1'b1, 60, 3, 2, 0, "R2/R10 p0s0");
        // R2 prescale 3, divide 4
        t_trace(2, 1, 4, 2, 1'b1, 1'b1, 150, -5, 0, 0, "R2 p2s1");
        // R7 interrupt disabled, divide 16
        t_trace(1, 3, 2, 0, 1'b1, 1'b0, 260, -5, 0, 0, "R7 ie0");
        // R5 one-shot stops at zero
        t_trace(0, 0, 2, 1, 1'b0, 1'b1, 40, -5, 0, 0, "R5 oneshot");
        t_freeze();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule